// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits (32 by default) over several cycles. It recodes one multiplier bit per cycle: each cycle it looks at the lowest multiplier bit together with a one-bit history register. It then adds the multiplicand to a running partial sum, subtracts it, or leaves the sum alone. The partial sum, multiplier and history bit then shift right together as one arithmetic shift. Negative operands need no separate sign correction, because the recoding handles them directly.

A caller presents both operands and pulses `start_i` while the unit is idle. The unit raises `busy_o` for `WIDTH` cycles. It then pulses `done_o` for one cycle and shows the full `2*WIDTH`-bit signed product on `product_o`. The product stays on `product_o` until the next operation is accepted.

Top module: `booth_mul_seq`

## Requirements
- R1: While reset is held and right after it, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A `start_i` seen at a clock edge while `busy_o` is 0 loads the operands. `busy_o` is 1 after that edge. `done_o` is 1 exactly `WIDTH` clock edges after the loading edge.
- R3: When `done_o` is 1, `product_o` equals the signed product of `mcand_i` and `mplier_i` as they were at the loading edge, given as a `2*WIDTH`-bit two's-complement value.
- R4: A step whose recoded bit pair (current multiplier bit, history bit) is 00 or 11 performs no addition. A multiplier of 0 therefore yields 0, and a multiplier of all ones yields the negated multiplicand.
- R5: A pair of 01 adds the multiplicand to the partial sum, and a pair of 10 subtracts it. Mixed bit patterns in the multiplier therefore give the exact product.
- R6: Each step shifts the partial sum right with its sign bit copied, so negative products come out correctly sign-extended.
- R7: An operand of -2^(WIDTH-1) on either side, or on both sides, still gives the exact product. This includes 2^(2*WIDTH-2) for both operands at the minimum.
- R8: `done_o` is high for exactly one cycle per operation, and `busy_o` is 0 whenever `done_o` is 1.
- R9: `start_i` asserted while `busy_o` is 1 is ignored. The running operation completes with its original operands.
- R10: After `done_o`, `product_o` keeps the result unchanged until another operation is accepted.
- R11: The internal step counter is loaded with `WIDTH` and drops by one on every step, so an operation takes exactly `WIDTH` steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a multiplication; honoured only when idle |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | High while steps are running |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2*WIDTH | Signed product |

## Verification
The bench builds the block at its default `WIDTH` of 32. At that width the full-scale corners can be reached: the most negative operand on each side, products near the top of the 64-bit range, and long runs of ones and zeros in the multiplier. Together these exercise every recoding pair. The latency of exactly 32 steps is checked against a cycle count for every result. Pseudo-random operand pairs add mixed bit patterns on top of the directed corner cases.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Arithmetic action chosen for one recoding step
  typedef enum logic [1:0] {
    OP_SKIP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_bit_i,
  input  logic      prev_bit_i,
  output booth_op_e op_o
);

  // 01: a run of ones has ended -> add; 10: a run of ones begins -> subtract
  always_comb begin
    unique case ({cur_bit_i, prev_bit_i})
      2'b01:   op_o = OP_ADD;
      2'b10:   op_o = OP_SUB;
      default: op_o = OP_SKIP;
    endcase
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int SUM_W = 33
) (
  input  logic [SUM_W-1:0] acc_i,
  input  logic [SUM_W-1:0] opnd_i,
  input  booth_op_e        op_i,
  output logic [SUM_W-1:0] sum_o
);

  always_comb begin
    unique case (op_i)
      OP_ADD:  sum_o = acc_i + opnd_i;
      OP_SUB:  sum_o = acc_i + ~opnd_i + SUM_W'(1);
      default: sum_o = acc_i;
    endcase
  end

endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int WIDTH = 32,
  localparam int CW   = $clog2(WIDTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q,  cnt_d;
  logic          cnt_en;
  logic          last_step;

  assign load_o    = start_i & ~busy_q;
  assign step_o    = busy_q;
  assign last_step = busy_q & (cnt_q == CW'(1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    done_d = last_step;
    if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = CW'(WIDTH);
      cnt_en = 1'b1;
    end else if (busy_q) begin
      cnt_d  = cnt_q - CW'(1);
      cnt_en = 1'b1;
      if (last_step) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R2 / R11: an accepted start arms the counter with the full step count
  a_r11_load_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && cnt_q == CW'(WIDTH)));

  // R11: each non-final step lowers the counter by exactly one
  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != CW'(1)) |=> (busy_q && cnt_q == $past(cnt_q) - CW'(1)));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: done is never reported while still stepping
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
  import booth_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AW   = WIDTH + 1,
  localparam int PW   = 2 * WIDTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [PW-1:0] product_o
);

  // Partial sum and multiplicand carry one guard bit so that
  // subtracting the most negative multiplicand cannot overflow.
  logic [AW-1:0]    acc_q,  acc_d;
  logic [AW-1:0]    mcd_q,  mcd_d;
  logic [WIDTH-1:0] mpl_q,  mpl_d;
  logic             hist_q, hist_d;
  logic             load, step, reg_en;
  booth_op_e        op;
  logic [AW-1:0]    sum;

  booth_seq_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  booth_recode recode_i (
    .cur_bit_i  (mpl_q[0]),
    .prev_bit_i (hist_q),
    .op_o       (op)
  );

  booth_addsub #(.SUM_W(AW)) addsub_i (
    .acc_i  (acc_q),
    .opnd_i (mcd_q),
    .op_i   (op),
    .sum_o  (sum)
  );

  assign reg_en = load | step;

  always_comb begin
    acc_d  = acc_q;
    mcd_d  = mcd_q;
    mpl_d  = mpl_q;
    hist_d = hist_q;
    if (load) begin
      acc_d  = '0;
      mcd_d  = {mcand_i[WIDTH-1], mcand_i};
      mpl_d  = mplier_i;
      hist_d = 1'b0;
    end else if (step) begin
      acc_d  = {sum[AW-1], sum[AW-1:1]};
      mpl_d  = {sum[0], mpl_q[WIDTH-1:1]};
      hist_d = mpl_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mcd_q  <= '0;
      mpl_q  <= '0;
      hist_q <= 1'b0;
    end else if (reg_en) begin
      acc_q  <= acc_d;
      mcd_q  <= mcd_d;
      mpl_q  <= mpl_d;
      hist_q <= hist_d;
    end
  end

  assign product_o = {acc_q[WIDTH-1:0], mpl_q};

  // R9: the multiplicand is frozen while an operation runs
  a_r9_mcand_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(mcd_q));

  // R4 / R6: a skip step is a pure sign-preserving shift of the partial sum
  a_r4_skip_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (mpl_q[0] == hist_q)) |=>
      (acc_q == {$past(acc_q[AW-1]), $past(acc_q[AW-1:1])}));

  // R10: an idle unit without a new start keeps its product
  a_r10_product_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(product_o));

  // R6: the history bit always takes the multiplier bit shifted out
  a_r6_hist_follows: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (hist_q == $past(mpl_q[0])));

endmodule

// File: tb/booth_mul_seq_tb_top.sv
module booth_mul_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;
  localparam int PW         = 2 * W;
  localparam int WATCHDOG   = 150000;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [W-1:0]  mcand_i;
  logic [W-1:0]  mplier_i;
  logic          busy_o;
  logic          done_o;
  logic [PW-1:0] product_o;

  int checks;
  int errors;
  int cyc;
  logic done_prev;
  logic [PW-1:0] last_exp;

  typedef struct packed {
    logic [PW-1:0] prod;
    logic [31:0]   due;
  } exp_t;
  exp_t sb_q[$];

  booth_mul_seq #(.WIDTH(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [PW-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
    logic [PW-1:0] ea, eb;
    ea = {{W{a[W-1]}}, a};
    eb = {{W{b[W-1]}}, b};
    return ea * eb;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [PW-1:0] act,
                     input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: advance to the falling edge, then run the monitor
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (done_prev)
      chk(done_o == 1'b0, "R8 done pulse width", PW'(done_o), '0);
    if (done_o) begin
      chk(busy_o == 1'b0, "R8 busy low at done", PW'(busy_o), '0);
      if (sb_q.size() == 0) begin
        chk(1'b0, "R9 unexpected result", product_o, '0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(product_o == e.prod, "R3 R5 R7 product", product_o, e.prod);
        chk(32'(cyc) == e.due, "R2 R11 latency", PW'(cyc), PW'(e.due));
        last_exp = e.prod;
      end
    end
    done_prev = done_o;
  endtask

  task automatic wait_idle();
    while (busy_o) tick();
  endtask

  // Driver: issue one operation and push its expected result
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    wait_idle();
    mcand_i  = a;
    mplier_i = b;
    start_i  = 1'b1;
    e.prod   = ref_mul(a, b);
    e.due    = 32'(cyc + 1 + W);
    sb_q.push_back(e);
    tick();
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", PW'(busy_o), PW'(1));
  endtask

  task automatic drain();
    for (int i = 0; i < 4 * W && sb_q.size() != 0; i++) tick();
    chk(sb_q.size() == 0, "R2 result delivered", PW'(sb_q.size()), '0);
  endtask

  initial begin
    checks    = 0;
    errors    = 0;
    cyc       = 0;
    done_prev = 1'b0;
    last_exp  = '0;
    start_i   = 1'b0;
    mcand_i   = '0;
    mplier_i  = '0;
    rst_n     = 1'b0;
    tick();
    tick();
    // R1: reset state
    chk(busy_o == 1'b0, "R1 busy in reset", PW'(busy_o), '0);
    chk(done_o == 1'b0, "R1 done in reset", PW'(done_o), '0);
    chk(product_o == '0, "R1 product in reset", product_o, '0);
    rst_n = 1'b1;
    tick();
    chk(busy_o == 1'b0 && product_o == '0, "R1 after reset", product_o, '0);

    // R4: all-zero and all-one multipliers
    run_op(32'd12345, 32'd0);
    run_op(32'hFFFF_FFFF, 32'd0);
    run_op(32'd777, 32'hFFFF_FFFF);
    run_op(32'hFFFF_FF00, 32'hFFFF_FFFF);
    // R5 / R6: mixed runs, negative results
    run_op(32'd5, 32'hFFFF_FFFD);
    run_op(32'hFFFF_FFF9, 32'd6);
    run_op(32'h5555_5555, 32'hAAAA_AAAA);
    run_op(32'h0F0F_00FF, 32'h7007_0F31);
    // R7: most negative operand corners
    run_op(32'h8000_0000, 32'h8000_0000);
    run_op(32'h8000_0000, 32'd1);
    run_op(32'd1, 32'h8000_0000);
    run_op(32'h8000_0000, 32'h7FFF_FFFF);
    run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF);
    run_op(32'h8000_0000, 32'hFFFF_FFFF);
    drain();

    // R10: product held while idle
    for (int i = 0; i < 5; i++) tick();
    chk(product_o == last_exp, "R10 product held", product_o, last_exp);

    // R9: start during busy is ignored
    run_op(32'd1000, 32'hFFFF_FC18);
    for (int i = 0; i < 6; i++) tick();
    mcand_i  = 32'h1234_5678;
    mplier_i = 32'h0000_0003;
    start_i  = 1'b1;
    tick();
    start_i  = 1'b0;
    mcand_i  = '0;
    mplier_i = '0;
    drain();
    for (int i = 0; i < 3; i++) tick();
    chk(busy_o == 1'b0, "R9 no extra operation", PW'(busy_o), '0);
    chk(product_o == ref_mul(32'd1000, 32'hFFFF_FC18), "R9 R10 original result",
        product_o, ref_mul(32'd1000, 32'hFFFF_FC18));

    // R3: back-to-back pseudo-random operands
    for (int i = 0; i < 200; i++) run_op($urandom, $urandom);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

endmodule